// File: doc/BRIEF.md
# Miss status holding register file

This block is a fixed pool of miss-tracking entries that sits beside a non-blocking cache. Each entry holds a line address, an access size, a ready time, a thread tag and a flag saying whether the request is in service with the next level. A new miss takes a free entry. Entries that are not in service form a waiting set. The waiting set is ordered by ready time, and when two times are equal the entry that arrived first stays ahead. A free-running time counter decides when a waiting entry may be issued.

The cache uses the block in four ways. It allocates entries. It looks up a line address against every allocated entry, or looks up an address range against the waiting entries only. It takes the next request from the issue port through a valid/ready handshake. It manages entries with one command per cycle: retry an in-service entry, move a waiting entry to the head of the order, free an entry, or squash all waiting entries of one thread.

The pool holds the nominal entry count plus the reserve count minus one entries. The full flag rises at the nominal count, so the remaining entries stay available for requests that are already in flight.

Top module: `mshr_file`

## Requirements
- R1: The pool holds N_NOM+N_RSV-1 entries. A command code 1 (allocate) takes the lowest-indexed free entry, which `alloc_idx_o` shows beforehand. It stores the address, size, ready time and thread, and `alloc_cnt_o` rises by one at the next edge.
- R2: An allocate issued while `free_avail_o` is low changes no state.
- R3: `full_o` is high exactly when `alloc_cnt_o` is at least N_NOM.
- R4: The waiting set is ordered by ready time. A newly waiting entry goes after every waiting entry whose ready time is less than or equal to its own.
- R5: The exact lookup compares `lk_addr_i` with every allocated entry, in service or not. `ex_mask_o` has one bit per matching entry, and `ex_idx_o` gives the lowest matching index.
- R6: The range lookup checks waiting entries only and reports the earliest one in waiting order that overlaps. An entry whose address is below the query address hits when its address plus its size exceeds the query address. Any other entry hits when the query address plus `lk_size_i` exceeds the entry's address.
- R7: `issue_valid_o` presents the earliest waiting entry whose ready time is not after `time_o`, and only while `cmd_i` is 0. A handshake with `issue_noresp_i` low moves that entry into service, and `svc_cnt_o` rises by one.
- R8: A handshake with `issue_noresp_i` high frees the issued entry instead of moving it into service.
- R9: Command code 2 (retry) returns an in-service entry to the waiting set, placed by its ready time, and `svc_cnt_o` falls by one. A retry of an entry that is not in service has no effect.
- R10: Command code 3 (front) puts a waiting entry at the head of the waiting order. It has no effect on an in-service entry.
- R11: Command code 4 (free) releases an allocated entry. `svc_cnt_o` also falls if that entry was in service. A free of an unallocated index has no effect.
- R12: Command code 5 (squash) frees every waiting entry whose thread equals `cmd_tid_i`. In-service entries of that thread stay allocated.
- R13: `time_o` is 0 during reset and advances by one on each clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code: 0 none, 1 allocate, 2 retry, 3 front, 4 free, 5 squash |
| cmd_idx_i | input | IDX_W | Entry index for retry, front and free |
| cmd_tid_i | input | TID_W | Thread for squash |
| alloc_addr_i | input | ADDR_W | Line address for allocate |
| alloc_size_i | input | SIZE_W | Access size for allocate |
| alloc_rdy_i | input | TIME_W | Ready time for allocate |
| alloc_tid_i | input | TID_W | Thread for allocate |
| alloc_idx_o | output | IDX_W | Index the next allocate will take |
| free_avail_o | output | 1 | At least one entry is free |
| full_o | output | 1 | Allocated count has reached N_NOM |
| issue_valid_o | output | 1 | An issuable entry is presented |
| issue_ready_i | input | 1 | Consumer takes the presented entry |
| issue_noresp_i | input | 1 | Issued request needs no response, so the entry is freed |
| issue_idx_o | output | IDX_W | Presented entry index |
| issue_addr_o | output | ADDR_W | Presented entry address |
| issue_size_o | output | SIZE_W | Presented entry size |
| issue_tid_o | output | TID_W | Presented entry thread |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_size_i | input | SIZE_W | Lookup size for the range lookup |
| ex_hit_o | output | 1 | Exact lookup hit |
| ex_idx_o | output | IDX_W | Lowest exact-hit index |
| ex_mask_o | output | POOL | All exact-hit entries |
| rg_hit_o | output | 1 | Range lookup hit |
| rg_idx_o | output | IDX_W | Earliest waiting entry that overlaps |
| alloc_cnt_o | output | CNT_W | Allocated entries |
| svc_cnt_o | output | CNT_W | In-service entries |
| time_o | output | TIME_W | Time counter |

## Verification
If an entry's order within the waiting set is corrupted, the wrong index appears on `issue_idx_o` or `rg_idx_o` in the same cycle as the lookup or issue that depends on it. The ranks cannot be read directly. For that reason the bench drains the waiting set through the issue port after each change to the order and compares the sequence of indices. A wrong valid or in-service flag shows up at the next edge as a count on `alloc_cnt_o` or `svc_cnt_o` that is off by one. It also shows up as an exact lookup that still hits after the entry was released.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_ALLOC  = 3'd1,
    CMD_RETRY  = 3'd2,
    CMD_FRONT  = 3'd3,
    CMD_FREE   = 3'd4,
    CMD_SQUASH = 3'd5
  } cmd_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int TIME_W = 16,
  parameter int TID_W  = 2,
  parameter int RANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [TIME_W-1:0] rdy_i,
  input  logic [TID_W-1:0]  tid_i,
  input  logic              to_wait_i,
  input  logic [RANK_W-1:0] wait_rank_i,
  input  logic              to_svc_i,
  input  logic              kill_i,
  input  logic              ins_en_i,
  input  logic [RANK_W-1:0] ins_pos_i,
  input  logic              front_en_i,
  input  logic [RANK_W-1:0] front_rank_i,
  input  logic [RANK_W-1:0] rm_dec_i,
  output logic              valid_o,
  output logic              svc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [TIME_W-1:0] rdy_o,
  output logic [TID_W-1:0]  tid_o,
  output logic [RANK_W-1:0] rank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      size_o <= '0;
      rdy_o  <= '0;
      tid_o  <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      size_o <= size_i;
      rdy_o  <= rdy_i;
      tid_o  <= tid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      svc_o   <= 1'b0;
      rank_o  <= '0;
    end else if (kill_i) begin
      valid_o <= 1'b0;
      svc_o   <= 1'b0;
    end else if (to_svc_i) begin
      svc_o <= 1'b1;
    end else if (to_wait_i) begin
      valid_o <= 1'b1;
      svc_o   <= 1'b0;
      rank_o  <= wait_rank_i;
    end else if (valid_o && !svc_o) begin
      // other waiting entries shift around the one that moved
      if (ins_en_i && rank_o >= ins_pos_i)
        rank_o <= rank_o + RANK_W'(1);
      else if (front_en_i && rank_o < front_rank_i)
        rank_o <= rank_o + RANK_W'(1);
      else
        rank_o <= rank_o - rm_dec_i;
    end
  end
endmodule

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N      = 5,
  parameter int RANK_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]             mask_i,
  input  logic [N-1:0][RANK_W-1:0] rank_i,
  output logic                     found_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [RANK_W-1:0]        rank_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!found_o || rank_i[i] < rank_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        rank_o  = rank_i[i];
      end
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_NOM  = 4,
  parameter int N_RSV  = 2,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int TIME_W = 16,
  parameter int TID_W  = 2,
  localparam int POOL   = N_NOM + N_RSV - 1,
  localparam int IDX_W  = $clog2(POOL),
  localparam int RANK_W = IDX_W,
  localparam int CNT_W  = $clog2(POOL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [TID_W-1:0]  cmd_tid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [SIZE_W-1:0] alloc_size_i,
  input  logic [TIME_W-1:0] alloc_rdy_i,
  input  logic [TID_W-1:0]  alloc_tid_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              free_avail_o,
  output logic              full_o,
  output logic              issue_valid_o,
  input  logic              issue_ready_i,
  input  logic              issue_noresp_i,
  output logic [IDX_W-1:0]  issue_idx_o,
  output logic [ADDR_W-1:0] issue_addr_o,
  output logic [SIZE_W-1:0] issue_size_o,
  output logic [TID_W-1:0]  issue_tid_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [SIZE_W-1:0] lk_size_i,
  output logic              ex_hit_o,
  output logic [IDX_W-1:0]  ex_idx_o,
  output logic [POOL-1:0]   ex_mask_o,
  output logic              rg_hit_o,
  output logic [IDX_W-1:0]  rg_idx_o,
  output logic [CNT_W-1:0]  alloc_cnt_o,
  output logic [CNT_W-1:0]  svc_cnt_o,
  output logic [TIME_W-1:0] time_o
);
  logic [POOL-1:0]             e_valid, e_svc, e_wait;
  logic [POOL-1:0][ADDR_W-1:0] e_addr;
  logic [POOL-1:0][SIZE_W-1:0] e_size;
  logic [POOL-1:0][TIME_W-1:0] e_rdy;
  logic [POOL-1:0][TID_W-1:0]  e_tid;
  logic [POOL-1:0][RANK_W-1:0] e_rank;

  logic [POOL-1:0] load, to_wait, to_svc, kill, rm_wait, tgt, free_sel, iss_sel, sq_mask;
  logic [POOL-1:0] iss_mask, rg_mask, ins_mask;
  logic [POOL-1:0][RANK_W-1:0] rm_dec;

  logic [TIME_W-1:0] time_q;
  logic [CNT_W-1:0]  wait_cnt;
  logic              iss_found, ins_found, rg_found;
  logic [IDX_W-1:0]  iss_idx, rg_idx_w, ins_idx_unused;
  logic [RANK_W-1:0] iss_rank_unused, rg_rank_unused, ins_rank, ins_pos, wait_rank, tgt_rank;
  logic [TIME_W-1:0] ins_rdy, tgt_rdy;
  logic              tgt_valid, tgt_svc, tgt_wait;
  logic              fire, alloc_go, retry_go, front_go, free_go;
  cmd_e              cmd;

  assign cmd    = cmd_e'(cmd_i);
  assign e_wait = e_valid & ~e_svc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_q + TIME_W'(1);
  end
  assign time_o = time_q;

  // counts and free slot
  always_comb begin
    alloc_cnt_o  = '0;
    svc_cnt_o    = '0;
    wait_cnt     = '0;
    free_avail_o = 1'b0;
    alloc_idx_o  = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      alloc_cnt_o = alloc_cnt_o + CNT_W'(e_valid[i]);
      svc_cnt_o   = svc_cnt_o + CNT_W'(e_svc[i]);
      wait_cnt    = wait_cnt + CNT_W'(e_wait[i]);
      if (!e_valid[i]) begin
        free_avail_o = 1'b1;
        alloc_idx_o  = IDX_W'(i);
      end
    end
  end
  assign full_o = alloc_cnt_o >= CNT_W'(N_NOM);

  // command target decode
  always_comb begin
    tgt_valid = 1'b0;
    tgt_svc   = 1'b0;
    tgt_rdy   = '0;
    tgt_rank  = '0;
    for (int i = 0; i < POOL; i++) begin
      tgt[i]      = (cmd_idx_i == IDX_W'(i));
      free_sel[i] = free_avail_o && (alloc_idx_o == IDX_W'(i));
      sq_mask[i]  = (cmd == CMD_SQUASH) && e_wait[i] && (e_tid[i] == cmd_tid_i);
      if (tgt[i]) begin
        tgt_valid = e_valid[i];
        tgt_svc   = e_svc[i];
        tgt_rdy   = e_rdy[i];
        tgt_rank  = e_rank[i];
      end
    end
  end
  assign tgt_wait = tgt_valid && !tgt_svc;

  // lookups and issue candidates
  always_comb begin
    for (int i = 0; i < POOL; i++) begin
      logic [ADDR_W:0] ea, qa;
      ea = {1'b0, e_addr[i]};
      qa = {1'b0, lk_addr_i};
      ex_mask_o[i] = e_valid[i] && (e_addr[i] == lk_addr_i);
      if (ea < qa) rg_mask[i] = e_wait[i] && (ea + (ADDR_W+1)'(e_size[i]) > qa);
      else         rg_mask[i] = e_wait[i] && (qa + (ADDR_W+1)'(lk_size_i) > ea);
      iss_mask[i] = e_wait[i] && (e_rdy[i] <= time_q);
      ins_mask[i] = e_wait[i] && (e_rdy[i] > ins_rdy);
    end
  end

  always_comb begin
    ex_hit_o = 1'b0;
    ex_idx_o = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (ex_mask_o[i]) begin
        ex_hit_o = 1'b1;
        ex_idx_o = IDX_W'(i);
      end
    end
  end

  mshr_pick #(.N(POOL), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick_iss (
    .mask_i(iss_mask), .rank_i(e_rank), .found_o(iss_found), .idx_o(iss_idx), .rank_o(iss_rank_unused)
  );
  mshr_pick #(.N(POOL), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick_rg (
    .mask_i(rg_mask), .rank_i(e_rank), .found_o(rg_found), .idx_o(rg_idx_w), .rank_o(rg_rank_unused)
  );
  mshr_pick #(.N(POOL), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick_ins (
    .mask_i(ins_mask), .rank_i(e_rank), .found_o(ins_found), .idx_o(ins_idx_unused), .rank_o(ins_rank)
  );
  assign rg_hit_o = rg_found;
  assign rg_idx_o = rg_idx_w;

  // new waiting entry goes before the first entry with a later ready time
  assign ins_rdy   = (cmd == CMD_ALLOC) ? alloc_rdy_i : tgt_rdy;
  assign ins_pos   = ins_found ? ins_rank : RANK_W'(wait_cnt);
  assign wait_rank = front_go ? '0 : ins_pos;

  assign issue_valid_o = (cmd == CMD_NOP) && iss_found;
  assign fire          = issue_valid_o && issue_ready_i;
  assign alloc_go      = (cmd == CMD_ALLOC) && free_avail_o;
  assign retry_go      = (cmd == CMD_RETRY) && tgt_svc;
  assign front_go      = (cmd == CMD_FRONT) && tgt_wait;
  assign free_go       = (cmd == CMD_FREE) && tgt_valid;

  always_comb begin
    issue_idx_o  = iss_idx;
    issue_addr_o = '0;
    issue_size_o = '0;
    issue_tid_o  = '0;
    for (int i = 0; i < POOL; i++) begin
      iss_sel[i] = iss_found && (iss_idx == IDX_W'(i));
      if (iss_sel[i]) begin
        issue_addr_o = e_addr[i];
        issue_size_o = e_size[i];
        issue_tid_o  = e_tid[i];
      end
      load[i]    = alloc_go && free_sel[i];
      to_wait[i] = load[i] || ((retry_go || front_go) && tgt[i]);
      to_svc[i]  = fire && iss_sel[i] && !issue_noresp_i;
      kill[i]    = (fire && iss_sel[i] && issue_noresp_i) || (free_go && tgt[i]) || sq_mask[i];
      rm_wait[i] = e_wait[i] && ((fire && iss_sel[i]) || (free_go && tgt[i]) || sq_mask[i]);
    end
  end

  // close the gaps left by removed waiting entries
  always_comb begin
    for (int i = 0; i < POOL; i++) begin
      rm_dec[i] = '0;
      for (int j = 0; j < POOL; j++)
        if (rm_wait[j] && e_rank[j] < e_rank[i]) rm_dec[i] = rm_dec[i] + RANK_W'(1);
    end
  end

  for (genvar g = 0; g < POOL; g++) begin : g_ent
    mshr_entry #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TIME_W(TIME_W), .TID_W(TID_W), .RANK_W(RANK_W)
    ) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load[g]),
      .addr_i      (alloc_addr_i),
      .size_i      (alloc_size_i),
      .rdy_i       (alloc_rdy_i),
      .tid_i       (alloc_tid_i),
      .to_wait_i   (to_wait[g]),
      .wait_rank_i (wait_rank),
      .to_svc_i    (to_svc[g]),
      .kill_i      (kill[g]),
      .ins_en_i    (alloc_go || retry_go),
      .ins_pos_i   (ins_pos),
      .front_en_i  (front_go),
      .front_rank_i(tgt_rank),
      .rm_dec_i    (rm_dec[g]),
      .valid_o     (e_valid[g]),
      .svc_o       (e_svc[g]),
      .addr_o      (e_addr[g]),
      .size_o      (e_size[g]),
      .rdy_o       (e_rdy[g]),
      .tid_o       (e_tid[g]),
      .rank_o      (e_rank[g])
    );
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N_NOM  = 4,
  parameter int N_RSV  = 2,
  parameter int TIME_W = 16,
  localparam int POOL  = N_NOM + N_RSV - 1,
  localparam int CNT_W = $clog2(POOL + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic              free_avail_o,
  input logic              full_o,
  input logic              issue_valid_o,
  input logic              issue_ready_i,
  input logic              issue_noresp_i,
  input logic [CNT_W-1:0]  alloc_cnt_o,
  input logic [CNT_W-1:0]  svc_cnt_o,
  input logic [TIME_W-1:0] time_o
);
  logic fire;
  assign fire = issue_valid_o && issue_ready_i;

  p_alloc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && free_avail_o) |=> alloc_cnt_o == $past(alloc_cnt_o) + CNT_W'(1));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && !free_avail_o) |=> $stable(alloc_cnt_o) && $stable(svc_cnt_o));

  p_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && free_avail_o && alloc_cnt_o == CNT_W'(N_NOM - 1)) |=> full_o);

  p_issue_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !issue_noresp_i) |=> svc_cnt_o == $past(svc_cnt_o) + CNT_W'(1) && $stable(alloc_cnt_o));

  p_noresp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && issue_noresp_i) |=> alloc_cnt_o == $past(alloc_cnt_o) - CNT_W'(1) && $stable(svc_cnt_o));

  p_svc_le_alloc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_cnt_o <= alloc_cnt_o);

  p_time_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> time_o == $past(time_o) + TIME_W'(1));
endmodule

bind mshr_file mshr_file_chk #(.N_NOM(N_NOM), .N_RSV(N_RSV), .TIME_W(TIME_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_i         (cmd_i),
  .free_avail_o  (free_avail_o),
  .full_o        (full_o),
  .issue_valid_o (issue_valid_o),
  .issue_ready_i (issue_ready_i),
  .issue_noresp_i(issue_noresp_i),
  .alloc_cnt_o   (alloc_cnt_o),
  .svc_cnt_o     (svc_cnt_o),
  .time_o        (time_o)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  localparam int CLK_PER = 10;
  localparam int POOL = 5;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [2:0]  cmd_idx_i = '0;
  logic [1:0]  cmd_tid_i = '0;
  logic [15:0] alloc_addr_i = '0;
  logic [7:0]  alloc_size_i = '0;
  logic [15:0] alloc_rdy_i = '0;
  logic [1:0]  alloc_tid_i = '0;
  logic [2:0]  alloc_idx_o;
  logic        free_avail_o, full_o, issue_valid_o;
  logic        issue_ready_i = 1'b0, issue_noresp_i = 1'b0;
  logic [2:0]  issue_idx_o;
  logic [15:0] issue_addr_o;
  logic [7:0]  issue_size_o;
  logic [1:0]  issue_tid_o;
  logic [15:0] lk_addr_i = '0;
  logic [7:0]  lk_size_i = '0;
  logic        ex_hit_o, rg_hit_o;
  logic [2:0]  ex_idx_o, rg_idx_o;
  logic [4:0]  ex_mask_o;
  logic [2:0]  alloc_cnt_o, svc_cnt_o;
  logic [15:0] time_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [15:0] V_ADDR [5] = '{16'h100, 16'h200, 16'h300, 16'h200, 16'h400};
  localparam logic [7:0]  V_SIZE [5] = '{8'h40, 8'h40, 8'h20, 8'h40, 8'h40};
  localparam logic [15:0] V_RDY  [5] = '{16'd3, 16'd1, 16'd3, 16'd0, 16'd1};
  localparam logic [1:0]  V_TID  [5] = '{2'd0, 2'd1, 2'd1, 2'd0, 2'd2};
  localparam logic        V_FULL [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [2:0]  ORD1   [5] = '{3'd2, 3'd3, 3'd1, 3'd4, 3'd0};

  always #(CLK_PER/2) clk = ~clk;

  mshr_file u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .cmd_idx_i(cmd_idx_i), .cmd_tid_i(cmd_tid_i),
    .alloc_addr_i(alloc_addr_i), .alloc_size_i(alloc_size_i), .alloc_rdy_i(alloc_rdy_i),
    .alloc_tid_i(alloc_tid_i), .alloc_idx_o(alloc_idx_o), .free_avail_o(free_avail_o),
    .full_o(full_o), .issue_valid_o(issue_valid_o), .issue_ready_i(issue_ready_i),
    .issue_noresp_i(issue_noresp_i), .issue_idx_o(issue_idx_o), .issue_addr_o(issue_addr_o),
    .issue_size_o(issue_size_o), .issue_tid_o(issue_tid_o), .lk_addr_i(lk_addr_i),
    .lk_size_i(lk_size_i), .ex_hit_o(ex_hit_o), .ex_idx_o(ex_idx_o), .ex_mask_o(ex_mask_o),
    .rg_hit_o(rg_hit_o), .rg_idx_o(rg_idx_o), .alloc_cnt_o(alloc_cnt_o), .svc_cnt_o(svc_cnt_o),
    .time_o(time_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_cmd(logic [2:0] c, logic [2:0] idx, logic [1:0] tid);
    cmd_i = c; cmd_idx_i = idx; cmd_tid_i = tid;
    tick();
    cmd_i = 3'd0;
    #1;
  endtask

  task automatic do_alloc(logic [15:0] a, logic [7:0] s, logic [15:0] r, logic [1:0] t);
    alloc_addr_i = a; alloc_size_i = s; alloc_rdy_i = r; alloc_tid_i = t;
    do_cmd(3'd1, 3'd0, 2'd0);
  endtask

  task automatic do_issue(logic nr);
    issue_ready_i = 1'b1; issue_noresp_i = nr;
    tick();
    issue_ready_i = 1'b0; issue_noresp_i = 1'b0;
    #1;
  endtask

  task automatic lookup(logic [15:0] a, logic [7:0] s);
    lk_addr_i = a; lk_size_i = s;
    #1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    logic [15:0] t0, rdy_f;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 time in reset", time_o, 0);
    rst_ni = 1'b1;
    #1;
    chk("R1 reset alloc_cnt", alloc_cnt_o, 0);
    chk("R7 reset svc_cnt", svc_cnt_o, 0);
    chk("R7 reset issue_valid", issue_valid_o, 0);
    chk("R3 reset full", full_o, 0);
    chk("R1 reset alloc_idx", alloc_idx_o, 0);
    t0 = time_o;
    repeat (10) tick();
    chk("R13 time advance", time_o, t0 + 16'd10);

    // vector table: allocate the pool
    for (int k = 0; k < POOL; k++) begin
      chk("R1 alloc_idx", alloc_idx_o, k);
      do_alloc(V_ADDR[k], V_SIZE[k], V_RDY[k], V_TID[k]);
      chk("R1 alloc_cnt", alloc_cnt_o, k + 1);
      chk("R3 full", full_o, V_FULL[k]);
    end
    chk("R2 free_avail", free_avail_o, 0);
    do_alloc(16'h700, 8'h40, 16'd0, 2'd3);
    chk("R2 alloc ignored", alloc_cnt_o, POOL);
    lookup(16'h700, 8'd0);
    chk("R2 no stray entry", ex_hit_o, 0);

    // exact lookup
    lookup(16'h200, 8'd0);
    chk("R5 exact hit", ex_hit_o, 1);
    chk("R5 exact idx", ex_idx_o, 1);
    chk("R5 exact mask", ex_mask_o, 5'b01010);
    lookup(16'h500, 8'd0);
    chk("R5 exact miss", ex_hit_o, 0);

    // waiting order 3,1,4,0,2
    chk("R4 head by time", issue_idx_o, 3);
    lookup(16'h120, 8'd4);
    chk("R6 below hit", {rg_hit_o, rg_idx_o}, {1'b1, 3'd0});
    lookup(16'h3F0, 8'h20);
    chk("R6 above hit", {rg_hit_o, rg_idx_o}, {1'b1, 3'd4});
    lookup(16'h140, 8'd0);
    chk("R6 touching miss", rg_hit_o, 0);
    lookup(16'h1F0, 8'h20);
    chk("R6 earliest waiting", {rg_hit_o, rg_idx_o}, {1'b1, 3'd3});

    do_cmd(3'd3, 3'd2, 2'd0);
    for (int k = 0; k < POOL; k++) begin
      chk("R10/R4 issue order", {issue_valid_o, issue_idx_o}, {1'b1, ORD1[k]});
      do_issue(1'b0);
    end
    chk("R7 svc_cnt", svc_cnt_o, POOL);
    chk("R7 nothing waiting", issue_valid_o, 0);
    lookup(16'h1F0, 8'h20);
    chk("R6 in-service ignored", rg_hit_o, 0);
    lookup(16'h200, 8'd0);
    chk("R5 in-service hit", ex_hit_o, 1);

    // retries reinsert by time: 4,1,0,2
    do_cmd(3'd2, 3'd0, 2'd0);
    do_cmd(3'd2, 3'd4, 2'd0);
    do_cmd(3'd2, 3'd2, 2'd0);
    do_cmd(3'd2, 3'd1, 2'd0);
    chk("R9 svc_cnt", svc_cnt_o, 1);
    chk("R9 head", issue_idx_o, 4);
    cmd_i = 3'd3; cmd_idx_i = 3'd3;
    #1;
    chk("R7 valid blocked by cmd", issue_valid_o, 0);
    tick();
    cmd_i = 3'd0;
    #1;
    chk("R10 front in-service ignored", {svc_cnt_o, issue_idx_o}, {3'd1, 3'd4});

    do_issue(1'b1);
    chk("R8 freed", {alloc_cnt_o, svc_cnt_o}, {3'd4, 3'd1});
    lookup(16'h400, 8'd0);
    chk("R8 gone", ex_hit_o, 0);
    chk("R9 next head", issue_idx_o, 1);

    do_cmd(3'd4, 3'd3, 2'd0);
    chk("R11 free in-service", {alloc_cnt_o, svc_cnt_o}, {3'd3, 3'd0});
    do_cmd(3'd4, 3'd0, 2'd0);
    chk("R11 free waiting", alloc_cnt_o, 2);
    do_cmd(3'd4, 3'd4, 2'd0);
    chk("R11 free unallocated", alloc_cnt_o, 2);
    chk("R11 head kept", issue_idx_o, 1);

    do_issue(1'b0);
    do_cmd(3'd5, 3'd0, 2'd1);
    chk("R12 squash counts", {alloc_cnt_o, svc_cnt_o}, {3'd1, 3'd1});
    chk("R12 nothing waiting", issue_valid_o, 0);
    lookup(16'h200, 8'd0);
    chk("R12 in-service kept", {ex_hit_o, ex_idx_o}, {1'b1, 3'd1});
    lookup(16'h300, 8'd0);
    chk("R12 waiting freed", ex_hit_o, 0);
    chk("R1 lowest free", alloc_idx_o, 0);

    // ready time in the future
    rdy_f = time_o + 16'd20;
    do_alloc(16'h500, 8'h40, rdy_f, 2'd3);
    for (int k = 0; k < 25; k++) begin
      chk("R7 ready gating", issue_valid_o, (time_o >= rdy_f));
      tick();
    end
    chk("R7 future entry issued", {issue_idx_o, issue_addr_o}, {3'd0, 16'h500});
    do_cmd(3'd2, 3'd0, 2'd0);
    chk("R9 retry of waiting ignored", {svc_cnt_o, issue_valid_o}, {3'd1, 1'b1});

    done = 1;
    report();
  end
endmodule